// File: doc/BRIEF.md
# Dual-Rate LFSR Test Pattern Source

This block supplies stimulus for a logic self-test. Two maximal-length linear feedback shift registers are combined into one parallel pattern. A fast register moves on to its next state with every pattern the consumer accepts. A slow register moves only after every DIV accepted patterns. A compile-time routing table connects each output bit to one stage of one of the two registers. Several outputs may share a single slow stage. Outputs fed by the slow register switch far less often, so the circuit under test dissipates less power. Because every fast stage and every slow stage reaches at least one output, a pattern stays distinct for as long as the pair of register states stays distinct.

The block is used in three steps. While the block is idle, software loads both seeds, then pulses `start` with the number of patterns to produce. Patterns leave through a valid/ready stream. A pattern counts as accepted on a clock edge where both `pat_valid` and `pat_ready` are high. While `pat_ready` is low, the offered pattern and all internal state hold. After the last accepted pattern, `pat_valid` falls, `done` rises, and the final pattern stays on `pat_data`.

Top module: `dualrate_tpg`

## Requirements
- R1: After reset, `pat_valid` and `done` are 0. The fast register holds FAST_DEF (0x01) and the slow register holds SLOW_DEF (0x01), so `pat_data` shows their mapped pattern.
- R2: A `seed_load` while idle loads `fast_seed` and `slow_seed` on the next edge. A seed value of zero is replaced by that register's default (0x01).
- R3: A `start` while idle latches `pat_count`, clears `done` and the rate phase, and raises `pat_valid` on the next edge. The first pattern offered is the current register state.
- R4: On each accepted pattern that is not the last, the fast register shifts left by one bit. The new bit 0 is the XOR of the state bits selected by FAST_TAPS (0xB8, the polynomial x^8+x^6+x^5+x^4+1).
- R5: The slow register takes the same kind of step, with SLOW_TAPS (0x30, x^6+x^5+1), on every DIV-th non-final acceptance counted from start (DIV=4). In a run of P patterns, each slow-driven output changes at most ceil(P/DIV) times.
- R6: Output bit i carries `slow[MAP_IDX[i]]` when MAP_SLOW[i] is 1, and `fast[MAP_IDX[i]]` otherwise. By default, bits 7..0 carry fast bits 7..0, bits 13..8 carry slow bits 5..0, bit 14 carries slow bit 2 and bit 15 carries slow bit 5. Outputs that map to the same stage are always equal.
- R7: While `pat_valid` is 1 and `pat_ready` is 0, `pat_data` and `pat_valid` hold unchanged.
- R8: On the acceptance that brings the count to the latched `pat_count`, `pat_valid` falls and `done` rises on the next edge. `pat_data` then holds until a seed load. A start with `pat_count` = 0 sets `done` without offering any pattern.
- R9: `seed_load` and `start` have no effect while a run is in progress.
- R10: Within a run no longer than the fast register's period (255 patterns), no accepted pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| seed_load | input | 1 | Load both seeds (honoured only when idle) |
| fast_seed | input | FAST_W | Seed for the fast register |
| slow_seed | input | SLOW_W | Seed for the slow register |
| pat_count | input | CNT_W | Number of patterns in the run |
| pat_data | output | OUT_W | Mapped test pattern |
| pat_valid | output | 1 | Pattern offered on the stream |
| pat_ready | input | 1 | Consumer accepts the pattern |
| done | output | 1 | Run complete, last pattern held |

## Verification
The generator is driven three ways. First, a short run with `pat_ready` held high checks the plain stepping rate of both registers and where the slow steps fall. Second, a longer run with `pat_ready` toggling at random shows whether a stall ever advances a register or the phase counter. That run also sends `start` and `seed_load` mid-run, which would move the sequence if they were not ignored. Third, zero seeds and a zero pattern count exercise the default substitution and the run that is complete at once. After each run, the accepted patterns are scanned for repeats, for the number of changes on each slow-driven bit, and for equality between bits that share a stage.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/dsl_lfsr.sv
module dsl_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] DEF  = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  logic         feedback;
  logic [W-1:0] seed_fix;

  assign feedback = ^(state & TAPS);
  // an all-zero state would lock the register, so it is never loaded
  assign seed_fix = (seed == '0) ? DEF : seed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DEF;
    end else if (load) begin
      state <= seed_fix;
    end else if (step) begin
      state <= {state[W-2:0], feedback};
    end
  end
endmodule

// File: rtl/dsl_rate_div.sv
module dsl_rate_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  output logic slow_step
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_same_rate
      assign slow_step = adv;
    end else begin : g_divided
      logic [PH_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          phase <= '0;
        end else if (adv) begin
          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
      end

      assign slow_step = adv && (phase == PH_LAST);
    end
  endgenerate
endmodule

// File: rtl/dsl_run_ctrl.sv
module dsl_run_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             seed_load,
  input  logic [CNT_W-1:0] pat_count,
  input  logic             pat_ready,
  output logic             pat_valid,
  output logic             done,
  output logic             adv,
  output logic             load_en,
  output logic             run_begin
);
  import dsl_pkg::*;

  run_state_e       state;
  logic [CNT_W-1:0] accepted;
  logic [CNT_W-1:0] limit;
  logic             fire;
  logic             last;

  assign pat_valid = (state == ST_RUN);
  assign done      = (state == ST_DONE);
  assign fire      = pat_valid && pat_ready;
  assign last      = (accepted == limit - 1'b1);
  // the final acceptance leaves the registers alone so the pattern holds
  assign adv       = fire && !last;
  assign load_en   = seed_load && (state != ST_RUN);
  assign run_begin = start && (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      accepted <= '0;
      limit    <= '0;
    end else if (run_begin) begin
      limit    <= pat_count;
      accepted <= '0;
      state    <= (pat_count == '0) ? ST_DONE : ST_RUN;
    end else if (fire) begin
      if (last) begin
        state <= ST_DONE;
      end else begin
        accepted <= accepted + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsl_map.sv
module dsl_map #(
  parameter int FAST_W = 8,
  parameter int SLOW_W = 6,
  parameter int OUT_W  = 16,
  parameter logic [OUT_W-1:0] MAP_SLOW = 16'hFF00,
  parameter logic [OUT_W-1:0][dsl_pkg::IDX_W-1:0] MAP_IDX = '0
) (
  input  logic [FAST_W-1:0] fast_bits,
  input  logic [SLOW_W-1:0] slow_bits,
  output logic [OUT_W-1:0]  pat_data
);
  generate
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
      localparam int K = int'(MAP_IDX[i]);
      if (MAP_SLOW[i]) begin : g_slow
        assign pat_data[i] = slow_bits[K];
      end else begin : g_fast
        assign pat_data[i] = fast_bits[K];
      end
    end
  endgenerate
endmodule

// File: rtl/dualrate_tpg.sv
module dualrate_tpg #(
  parameter int FAST_W = 8,
  parameter int SLOW_W = 6,
  parameter int OUT_W  = 16,
  parameter int DIV    = 4,
  parameter int CNT_W  = 16,
  parameter logic [FAST_W-1:0] FAST_TAPS = 8'hB8,
  parameter logic [SLOW_W-1:0] SLOW_TAPS = 6'h30,
  parameter logic [FAST_W-1:0] FAST_DEF  = 8'h01,
  parameter logic [SLOW_W-1:0] SLOW_DEF  = 6'h01,
  parameter logic [OUT_W-1:0]  MAP_SLOW  = 16'hFF00,
  parameter logic [OUT_W-1:0][dsl_pkg::IDX_W-1:0] MAP_IDX = {
    8'd5, 8'd2, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0,
    8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seed_load,
  input  logic [FAST_W-1:0] fast_seed,
  input  logic [SLOW_W-1:0] slow_seed,
  input  logic [CNT_W-1:0]  pat_count,
  output logic [OUT_W-1:0]  pat_data,
  output logic              pat_valid,
  input  logic              pat_ready,
  output logic              done
);
  logic              adv;
  logic              load_en;
  logic              run_begin;
  logic              slow_step;
  logic [FAST_W-1:0] fast_q;
  logic [SLOW_W-1:0] slow_q;

  dsl_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load),
    .pat_count(pat_count), .pat_ready(pat_ready), .pat_valid(pat_valid),
    .done(done), .adv(adv), .load_en(load_en), .run_begin(run_begin)
  );

  dsl_rate_div #(.DIV(DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .clear(run_begin), .adv(adv),
    .slow_step(slow_step)
  );

  dsl_lfsr #(.W(FAST_W), .TAPS(FAST_TAPS), .DEF(FAST_DEF)) u_fast (
    .clk(clk), .rst_n(rst_n), .load(load_en), .seed(fast_seed),
    .step(adv), .state(fast_q)
  );

  dsl_lfsr #(.W(SLOW_W), .TAPS(SLOW_TAPS), .DEF(SLOW_DEF)) u_slow (
    .clk(clk), .rst_n(rst_n), .load(load_en), .seed(slow_seed),
    .step(slow_step), .state(slow_q)
  );

  dsl_map #(
    .FAST_W(FAST_W), .SLOW_W(SLOW_W), .OUT_W(OUT_W),
    .MAP_SLOW(MAP_SLOW), .MAP_IDX(MAP_IDX)
  ) u_map (
    .fast_bits(fast_q), .slow_bits(slow_q), .pat_data(pat_data)
  );
endmodule

// File: rtl/dualrate_tpg_chk.sv
module dualrate_tpg_chk #(
  parameter int OUT_W = 16,
  parameter int CNT_W = 16,
  parameter logic [OUT_W-1:0] MAP_SLOW = 16'hFF00,
  parameter logic [OUT_W-1:0][dsl_pkg::IDX_W-1:0] MAP_IDX = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             seed_load,
  input logic [CNT_W-1:0] pat_count,
  input logic [OUT_W-1:0] pat_data,
  input logic             pat_valid,
  input logic             pat_ready,
  input logic             done
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready) |=> (pat_valid && $stable(pat_data)));

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && pat_valid));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !seed_load) |=> $stable(pat_data));

  // R3
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pat_valid && pat_count != '0) |=> (pat_valid && !done));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready && (start || seed_load)) |=> pat_valid);

  generate
    for (genvar i = 0; i < OUT_W; i++) begin : g_a
      for (genvar j = i + 1; j < OUT_W; j++) begin : g_b
        if (MAP_SLOW[i] == MAP_SLOW[j] && MAP_IDX[i] == MAP_IDX[j]) begin : g_pair
          // R6
          shared_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pat_data[i] == pat_data[j]);
        end
      end
    end
  endgenerate
endmodule

bind dualrate_tpg dualrate_tpg_chk #(
  .OUT_W(OUT_W), .CNT_W(CNT_W), .MAP_SLOW(MAP_SLOW), .MAP_IDX(MAP_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load),
  .pat_count(pat_count), .pat_data(pat_data), .pat_valid(pat_valid),
  .pat_ready(pat_ready), .done(done)
);

// File: tb/dualrate_tpg_test.sv
module dualrate_tpg_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        seed_load = 1'b0;
  logic [7:0]  fast_seed = '0;
  logic [5:0]  slow_seed = '0;
  logic [15:0] pat_count = '0;
  logic [15:0] pat_data;
  logic        pat_valid;
  logic        pat_ready = 1'b1;
  logic        done;
  int          ready_mode = 0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int  m_fast, m_slow, m_phase, m_cnt, m_lim;
  bit  m_run, m_done;
  logic [15:0] accq[$];

  dualrate_tpg uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load),
    .fast_seed(fast_seed), .slow_seed(slow_seed), .pat_count(pat_count),
    .pat_data(pat_data), .pat_valid(pat_valid), .pat_ready(pat_ready),
    .done(done)
  );

  always #5 clk = ~clk;

  function automatic int lfsr_next(int s, int w, int taps);
    int fb;
    fb = $countones(s & taps) & 1;
    return ((s << 1) | fb) & ((1 << w) - 1);
  endfunction

  // R6 default routing as stated in the requirement
  function automatic logic [15:0] expect_pat(int f, int s);
    logic [15:0] p;
    p[7:0]  = f[7:0];
    p[13:8] = s[5:0];
    p[14]   = s[2];
    p[15]   = s[5];
    return p;
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model, advanced on the edge from inputs set at the prior negedge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fast = 1; m_slow = 1; m_phase = 0; m_cnt = 0; m_lim = 0;
      m_run = 0; m_done = 0;
    end else if (m_run) begin
      if (pat_ready) begin
        accq.push_back(expect_pat(m_fast, m_slow));
        if (m_cnt + 1 == m_lim) begin
          m_run = 0; m_done = 1;
        end else begin
          m_cnt++;
          m_fast = lfsr_next(m_fast, 8, 'hB8);
          if (m_phase == DIV - 1) begin
            m_phase = 0;
            m_slow = lfsr_next(m_slow, 6, 'h30);
          end else begin
            m_phase++;
          end
        end
      end
    end else begin
      if (seed_load) begin
        m_fast = (fast_seed == 0) ? 1 : int'(fast_seed);
        m_slow = (slow_seed == 0) ? 1 : int'(slow_seed);
      end
      if (start) begin
        m_lim = int'(pat_count); m_cnt = 0; m_phase = 0;
        if (pat_count == 0) begin m_done = 1; m_run = 0; end
        else begin m_done = 0; m_run = 1; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 valid", pat_valid == m_run, int'(pat_valid), int'(m_run));
      check("R8 done", done == m_done, int'(done), int'(m_done));
      check("R4 data", pat_data == expect_pat(m_fast, m_slow),
            int'(pat_data), int'(expect_pat(m_fast, m_slow)));
    end
    pat_ready <= (ready_mode != 0) ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      report();
    end
  end

  task automatic run_checks(int p);
    int maxtog, tog, dup;
    maxtog = 0;
    for (int b = 8; b < 16; b++) begin
      tog = 0;
      for (int k = 1; k < accq.size(); k++)
        if (accq[k][b] != accq[k-1][b]) tog++;
      if (tog > maxtog) maxtog = tog;
    end
    // R5
    check("R5 slow toggles", maxtog <= (p + DIV - 1) / DIV, maxtog, (p + DIV - 1) / DIV);
    dup = 0;
    for (int a = 0; a < accq.size(); a++)
      for (int c = a + 1; c < accq.size(); c++)
        if (accq[a] == accq[c]) dup++;
    // R10
    check("R10 unique", dup == 0, dup, 0);
    dup = 0;
    for (int a = 0; a < accq.size(); a++)
      if (accq[a][14] != accq[a][10] || accq[a][15] != accq[a][13]) dup++;
    // R6
    check("R6 shared", dup == 0, dup, 0);
    check("R8 count", accq.size() == p, accq.size(), p);
  endtask

  task automatic wait_done;
    while (!m_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    check("R1 valid", pat_valid == 1'b0, int'(pat_valid), 0);
    check("R1 done", done == 1'b0, int'(done), 0);
    check("R1 data", pat_data == expect_pat(1, 1), int'(pat_data), int'(expect_pat(1, 1)));

    // R2 load, R3 start, ready held high
    seed_load = 1; fast_seed = 8'h5A; slow_seed = 6'h2B;
    @(negedge clk);
    seed_load = 0;
    check("R2 seeds", pat_data == expect_pat('h5A, 'h2B), int'(pat_data), int'(expect_pat('h5A, 'h2B)));
    start = 1; pat_count = 16'd40;
    @(negedge clk);
    start = 0;
    check("R3 valid", pat_valid == 1'b1, int'(pat_valid), 1);
    accq.delete();
    wait_done();
    run_checks(40);

    // R7 random back-pressure, R9 disturbances mid-run
    seed_load = 1; fast_seed = 8'hA7; slow_seed = 6'h11;
    @(negedge clk);
    seed_load = 0;
    accq.delete();
    ready_mode = 1;
    start = 1; pat_count = 16'd200;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    // R9
    seed_load = 1; start = 1; fast_seed = 8'h33; slow_seed = 6'h07; pat_count = 16'd3;
    @(negedge clk);
    seed_load = 0; start = 0;
    check("R9 still running", pat_valid == 1'b1, int'(pat_valid), 1);
    wait_done();
    ready_mode = 0;
    run_checks(200);

    // R2 zero seed substitution
    seed_load = 1; fast_seed = 8'h00; slow_seed = 6'h00;
    @(negedge clk);
    seed_load = 0;
    check("R2 zero seed", pat_data == expect_pat(1, 1), int'(pat_data), int'(expect_pat(1, 1)));

    // R8 empty run
    start = 1; pat_count = 16'd0;
    @(negedge clk);
    start = 0;
    check("R8 empty done", done == 1'b1 && pat_valid == 1'b0, int'({done, pat_valid}), 2);
    repeat (4) @(negedge clk);
    report();
  end
endmodule